// File: doc/BRIEF.md
# PCM Timeslot Drop/Insert Marker

This block follows the bit position inside a serial PCM frame on two independent paths and raises a strobe on every bit that belongs to a selected part of the frame. On the receive path the drop strobe tells downstream logic which bits on the receive serial line belong to the selected timeslots or the framing bit. On the transmit path the insert strobe marks the bits that are taken from an alternate serial source. While it is high, the transmit serial output carries the alternate stream instead of the normal one.

Each path has its own clock, its own frame sync and its own selection bitmap. A bitmap holds one bit for the framing bit and one bit for each timeslot. A bitmap is captured once per frame, so software-side changes never split a frame. Both serial sources on the transmit side share one frame layout, so replacement happens bit for bit with no buffering.

Top module: `pcm_slot_marker`

## Requirements
- R1: A frame is 1 + SLOTS*SLOT_BITS bits long (193 by default). Position 0 is the framing bit and timeslot k (k = 1..SLOTS) occupies positions 1+(k-1)*SLOT_BITS to k*SLOT_BITS. A sync input high at a rising clock edge makes the bit that starts at that edge position 0, and the strobe for it is valid from that same edge.
- R2: drop_mark is high for exactly the SLOT_BITS bit times of every timeslot k whose drop_map bit k is 1, and low for every timeslot whose bit is 0.
- R3: drop_map bit 0 selects the framing bit. drop_mark is then high for that one bit time only, and ins_map bit 0 acts the same way for ins_mark.
- R4: Any set of map bits may be 1, including none and all. Marks of neighbouring selected positions join into one continuous high run.
- R5: ins_mark follows the rules of R2 and R3 on the transmit clock, using ins_map and tx_sync, independently of the receive side.
- R6: tx_out equals ins_data in every bit time where ins_mark is high, and equals tx_data otherwise.
- R7: With no sync, the position counter moves from the last position of a frame back to position 0, and a new frame starts with the map bits present at that edge.
- R8: A map is captured at the edge that starts a frame. A change to drop_map or ins_map within a frame has no effect on the strobes until the next frame starts.
- R9: While rst_n is low, drop_mark and ins_mark are low and tx_out equals tx_data.
- R10: The receive and transmit sides use separate clocks and syncs. Frame timing on one side does not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive bit clock |
| tx_clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sync | input | 1 | Receive frame sync; next bit is the framing bit |
| tx_sync | input | 1 | Transmit frame sync; next bit is the framing bit |
| drop_map | input | SLOTS+1 | Receive selection; bit 0 framing bit, bit k timeslot k |
| ins_map | input | SLOTS+1 | Transmit selection; bit 0 framing bit, bit k timeslot k |
| tx_data | input | 1 | Normal transmit serial data |
| ins_data | input | 1 | Alternate transmit serial data |
| drop_mark | output | 1 | Receive strobe for selected bits |
| ins_mark | output | 1 | Transmit strobe for selected bits |
| tx_out | output | 1 | Transmit serial output after selection |

## Verification
The bench covers the frame edges: the one-bit framing mark next to timeslot 1, the last timeslot that meets the wrap back to position 0, and the empty and full maps. A counter that is off by one shows up as strobes shifted by one bit or seven or nine bits long. A map edit made in the middle of a frame tests capture at the boundary; a design that reads the map live would change the strobe within the frame. A run with no sync checks the free-running wrap, and streams with opposite polarity on the two transmit sources catch a swapped or delayed multiplexer.

// File: rtl/pcm_slot_marker.sv
module pcm_slot_marker #(
  parameter int SLOTS     = 24,
  parameter int SLOT_BITS = 8
) (
  input  logic             rx_clk,
  input  logic             tx_clk,
  input  logic             rst_n,
  input  logic             rx_sync,
  input  logic             tx_sync,
  input  logic [SLOTS:0]   drop_map,
  input  logic [SLOTS:0]   ins_map,
  input  logic             tx_data,
  input  logic             ins_data,
  output logic             drop_mark,
  output logic             ins_mark,
  output logic             tx_out
);
  localparam int SW = $clog2(SLOTS + 1);
  localparam int BW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

  logic [1:0]     side_clk, side_sync, side_mark;
  logic [SLOTS:0] side_map [2];

  assign side_clk    = {tx_clk, rx_clk};
  assign side_sync   = {tx_sync, rx_sync};
  assign side_map[0] = drop_map;
  assign side_map[1] = ins_map;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [SW-1:0]  slot_q, slot_d;
    logic [BW-1:0]  bit_q, bit_d;
    logic [SLOTS:0] act_q;
    logic           mark_q;

    always_comb begin
      slot_d = slot_q;
      bit_d  = bit_q;
      if (side_sync[s]) begin
        slot_d = '0;
        bit_d  = '0;
      end else if (slot_q == '0) begin
        slot_d = SW'(1);
        bit_d  = '0;
      end else if (bit_q == BW'(SLOT_BITS - 1)) begin
        bit_d  = '0;
        slot_d = (slot_q == SW'(SLOTS)) ? '0 : slot_q + SW'(1);
      end else begin
        bit_d  = bit_q + BW'(1);
      end
    end

    always_ff @(posedge side_clk[s] or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= SW'(SLOTS);
        bit_q  <= BW'(SLOT_BITS - 1);
        act_q  <= '0;
        mark_q <= 1'b0;
      end else begin
        slot_q <= slot_d;
        bit_q  <= bit_d;
        if (slot_d == '0) begin
          act_q  <= side_map[s];
          mark_q <= side_map[s][0];
        end else begin
          mark_q <= act_q[slot_d];
        end
      end
    end

    assign side_mark[s] = mark_q;
  end

  assign drop_mark = side_mark[0];
  assign ins_mark  = side_mark[1];
  assign tx_out    = ins_mark ? ins_data : tx_data;
endmodule

// File: rtl/pcm_slot_marker_chk.sv
module pcm_slot_marker_chk #(
  parameter int SLOTS     = 24,
  parameter int SLOT_BITS = 8
) (
  input logic           rx_clk,
  input logic           tx_clk,
  input logic           rst_n,
  input logic           rx_sync,
  input logic           tx_sync,
  input logic [SLOTS:0] drop_map,
  input logic [SLOTS:0] ins_map,
  input logic           tx_data,
  input logic           ins_data,
  input logic           drop_mark,
  input logic           ins_mark,
  input logic           tx_out
);
  localparam int FRAME = 1 + SLOTS * SLOT_BITS;
  localparam int PW    = $clog2(FRAME);

  logic [PW-1:0] rx_pos, tx_pos;

  always_ff @(posedge rx_clk or negedge rst_n)
    if (!rst_n)       rx_pos <= PW'(FRAME - 1);
    else if (rx_sync) rx_pos <= '0;
    else              rx_pos <= (rx_pos == PW'(FRAME - 1)) ? '0 : rx_pos + PW'(1);

  always_ff @(posedge tx_clk or negedge rst_n)
    if (!rst_n)       tx_pos <= PW'(FRAME - 1);
    else if (tx_sync) tx_pos <= '0;
    else              tx_pos <= (tx_pos == PW'(FRAME - 1)) ? '0 : tx_pos + PW'(1);

  // R1 R3: framing-bit strobe follows map bit 0 at the edge after sync
  a_r3_rx_fbit: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_sync |=> drop_mark == $past(drop_map[0]));
  a_r3_tx_fbit: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tx_sync |=> ins_mark == $past(ins_map[0]));

  // R2 R8: strobe cannot change inside a timeslot
  a_r2_rx_slot_hold: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (int'(rx_pos) >= 2 && ((int'(rx_pos) - 1) % SLOT_BITS) != 0) |-> $stable(drop_mark));
  a_r5_tx_slot_hold: assert property (@(posedge tx_clk) disable iff (!rst_n)
    (int'(tx_pos) >= 2 && ((int'(tx_pos) - 1) % SLOT_BITS) != 0) |-> $stable(ins_mark));

  // R6: output source follows the insert strobe
  a_r6_insert_src: assert property (@(posedge tx_clk) disable iff (!rst_n)
    ins_mark |-> tx_out == ins_data);
  a_r6_normal_src: assert property (@(posedge tx_clk) disable iff (!rst_n)
    !ins_mark |-> tx_out == tx_data);

  // R9: strobes idle during reset
  a_r9_rx_reset: assert property (@(posedge rx_clk) !rst_n |-> !drop_mark);
  a_r9_tx_reset: assert property (@(posedge tx_clk) !rst_n |-> (!ins_mark && tx_out == tx_data));
endmodule

bind pcm_slot_marker pcm_slot_marker_chk #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_chk (.*);

// File: tb/tb_pcm_slot_marker.sv
module tb_pcm_slot_marker;
  localparam int SLOTS = 24;
  localparam int SB    = 8;
  localparam int FRAME = 1 + SLOTS * SB;

  logic rx_clk = 1'b0, tx_clk = 1'b0, rst_n = 1'b1;
  logic rx_sync = 1'b0, tx_sync = 1'b0;
  logic [SLOTS:0] drop_map = '0, ins_map = '0;
  logic tx_data = 1'b1, ins_data = 1'b0;
  logic drop_mark, ins_mark, tx_out;

  pcm_slot_marker #(.SLOTS(SLOTS), .SLOT_BITS(SB)) dut (.*);

  always #10 rx_clk = ~rx_clk;
  initial begin #7; forever #10 tx_clk = ~tx_clk; end

  int n_checks = 0, n_fail = 0;
  logic       rx_q [$];
  string      rx_t [$];
  logic [2:0] tx_q [$];
  string      tx_t [$];
  logic       rx_e;
  logic [2:0] tx_e;
  string      rx_s, tx_s;

  function automatic logic want(logic [SLOTS:0] m, int p);
    return (p == 0) ? m[0] : m[(p - 1) / SB + 1];
  endfunction

  function automatic logic pat(int p, int seed);
    return logic'(((p * 5 + seed) >> 1) & 1);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rx_frame(logic [SLOTS:0] m, bit sync, int chg, logic [SLOTS:0] m2);
    @(negedge rx_clk);
    rx_sync  = sync;
    drop_map = m;
    for (int p = 0; p < FRAME; p++) begin
      rx_q.push_back(want(m, p));
      if (!sync)                 rx_t.push_back("R7 rx wrap");
      else if (chg >= 0 && p >= chg) rx_t.push_back("R8 rx map held");
      else if (p == 0)           rx_t.push_back("R3 rx framing bit");
      else                       rx_t.push_back("R2 rx timeslot");
    end
    for (int p = 1; p < FRAME; p++) begin
      @(negedge rx_clk);
      rx_sync = 1'b0;
      if (p == chg) drop_map = m2;
    end
  endtask

  task automatic tx_frame(logic [SLOTS:0] m, bit sync, int chg, logic [SLOTS:0] m2, int seed);
    for (int p = 0; p < FRAME; p++) begin
      logic mk, td;
      @(negedge tx_clk);
      if (p == 0) begin
        tx_sync = sync;
        ins_map = m;
        for (int k = 0; k < FRAME; k++) begin
          mk = want(m, k);
          td = pat(k, seed);
          tx_q.push_back({mk, td, mk ? ~td : td});
          if (!sync)                     tx_t.push_back("R7 tx wrap");
          else if (chg >= 0 && k >= chg) tx_t.push_back("R8 tx map held");
          else if (k == 0)               tx_t.push_back("R3 tx framing bit");
          else                           tx_t.push_back("R5 tx timeslot");
        end
      end else begin
        tx_sync = 1'b0;
        if (p == chg) ins_map = m2;
      end
      tx_data  = pat(p, seed);
      ins_data = ~pat(p, seed);
    end
  endtask

  always @(posedge rx_clk) begin
    #5;
    if (rx_q.size() > 0) begin
      rx_e = rx_q.pop_front();
      rx_s = rx_t.pop_front();
      check(rx_s, drop_mark, rx_e);
    end
  end

  always @(posedge tx_clk) begin
    #5;
    if (tx_q.size() > 0) begin
      tx_e = tx_q.pop_front();
      tx_s = tx_t.pop_front();
      check(tx_s, ins_mark, tx_e[2]);
      check("R6 tx_out source", tx_out, tx_e[0]);
    end
  end

  task automatic rx_seq();
    rx_frame('0, 1'b1, -1, '0);                        // R4 none
    rx_frame({(SLOTS+1){1'b1}}, 1'b1, -1, '0);         // R4 all
    rx_frame(25'h0AA_AA55, 1'b1, -1, '0);              // R2 mixed
    rx_frame(25'h000_0001, 1'b1, -1, '0);              // R3 framing only
    rx_frame(25'h100_0003, 1'b0, -1, '0);              // R7 free wrap, last slot
    rx_frame(25'h0F0_F0F1, 1'b1, 100, 25'h10F_0F0E);   // R8 mid-frame edit
    rx_frame(25'h10F_0F0E, 1'b1, -1, '0);
  endtask

  task automatic tx_seq();
    repeat (37) @(negedge tx_clk);                     // R10 offset framing
    tx_frame('0, 1'b1, -1, '0, 3);
    tx_frame({(SLOTS+1){1'b1}}, 1'b1, -1, '0, 1);
    tx_frame(25'h155_5402, 1'b1, -1, '0, 0);
    tx_frame(25'h000_0001, 1'b1, -1, '0, 2);
    tx_frame(25'h180_0001, 1'b0, -1, '0, 5);
    tx_frame(25'h033_3333, 1'b1, 60, 25'h1CC_CCCC, 4);
    tx_frame(25'h1CC_CCCC, 1'b1, -1, '0, 6);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge rx_clk);
    check("R9 drop_mark in reset", drop_mark, 1'b0);
    check("R9 ins_mark in reset", ins_mark, 1'b0);
    check("R9 tx_out in reset", tx_out, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge rx_clk);
    check("R9 drop_mark after reset", drop_mark, 1'b0);
    check("R9 ins_mark after reset", ins_mark, 1'b0);
    fork
      rx_seq();
      tx_seq();
    join
    repeat (4) @(negedge rx_clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule